// File: doc/BRIEF.md
# Sound Effect Playback Sequencer

This block steps through a sound clip held in a byte-wide ROM, one 16-bit sample at a time. The ROM is combinational. The block drives an address and reads the byte that comes back once a short settling delay has passed. A one-cycle play strobe with a 3-bit selector starts a clip. The upper three address bits choose a partition of the ROM, and a counter supplies the low bits. Each sample is stored as two bytes, low byte first. The block reads both bytes, joins them into a sample, and presents the sample to the serial DAC driver together with a one-cycle load strobe.

Samples leave the block at a fixed pace of one every `PERIOD` clocks. With a 4 MHz clock and the default of 250, that gives 16 kHz. Selectors 0 to 3 each play a single partition. Selectors 4 to 7 play a clip twice as long that runs through an even partition and then the odd partition above it. A strobe that arrives while a clip is playing is dropped.

Top module: `audio_sfx_player`

## Requirements
- R1: After reset, `playing_o` and `load_o` are low, and `rom_addr_o` is zero.
- R2: A play strobe sampled while idle starts a clip. `playing_o` is high on the next cycle, and `rom_addr_o` then holds the start partition with all low `CNT_W` bits zero.
- R3: Selector bit 2 clear plays partition `sel` alone. Selector bit 2 set ignores bit 0: playback starts in partition `{sel[2:1],0}` and continues into partition `{sel[2:1],1}`.
- R4: Within a partition, sample k uses byte offsets 2k (low byte) and 2k+1 (high byte). `sample_o` equals `{high, low}`. Each address is held for `WAIT_CYC` full cycles before its byte is captured.
- R5: `load_o` is high for exactly one cycle per sample, and `load_o` is only high while `playing_o` is high. The first strobe comes `2*WAIT_CYC` cycles after the play strobe is accepted, and each later strobe comes exactly `PERIOD` cycles after the one before.
- R6: A single-partition clip issues 2^(CNT_W-1) samples and a double clip issues twice as many. The last sample of each clip is read from the last two bytes before the next clip's region begins.
- R7: A play strobe received while `playing_o` is high has no effect: the clip, its samples and its timing continue unchanged.
- R8: `playing_o` falls on the cycle after the final load strobe. A play strobe on any later cycle is accepted.

Ports use widths based on the parameters `CNT_W`, `PERIOD` and `WAIT_CYC`, where AW = 3 + CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_i | input | 1 | One-cycle request to start a clip |
| sel_i | input | 3 | Clip selector, sampled together with `play_i` |
| rom_addr_o | output | AW | ROM byte address |
| rom_data_i | input | 8 | ROM byte returned for `rom_addr_o` |
| sample_o | output | 16 | Assembled sample, valid while `load_o` is high |
| load_o | output | 1 | One-cycle strobe to the DAC driver |
| playing_o | output | 1 | High from acceptance until the cycle after the final strobe |

## Verification
Cycle 0 is the edge that samples the strobe. The bench counts every cycle from there. The start address is due right after that edge. The strobe for sample k is due `k*PERIOD + 2*WAIT_CYC` cycles later. `playing_o` must be high up to and including the final strobe's cycle and low from the next cycle on. The bench samples on the falling edge at each of these exact offsets and compares `load_o`, `sample_o` and `playing_o` against values it computes from a ROM formula. A second strobe is injected mid-clip, and the bench checks that every due cycle still lands as expected.

// File: rtl/audio_sfx_pkg.sv
package audio_sfx_pkg;

    localparam int SEL_W  = 3;
    localparam int PART_W = 3;
    localparam int BYTE_W = 8;
    localparam int SMP_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO_WAIT,
        ST_HI_WAIT,
        ST_GAP,
        ST_LAST
    } sfx_state_e;

endpackage

// File: rtl/sfx_region_map.sv
module sfx_region_map
    import audio_sfx_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    output logic [PART_W-1:0] base_part_o,
    output logic              long_o
);

    always_comb begin
        long_o = sel_i[SEL_W-1];
        if (sel_i[SEL_W-1]) begin
            base_part_o = {sel_i[SEL_W-1:1], 1'b0};
        end else begin
            base_part_o = sel_i;
        end
    end

endmodule

// File: rtl/sfx_addr_counter.sv
module sfx_addr_counter
    import audio_sfx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [PART_W-1:0]       base_part_i,
    input  logic                    long_i,
    input  logic                    hi_byte_i,
    input  logic                    advance_i,
    output logic [PART_W+CNT_W-1:0] addr_o,
    output logic                    last_o
);

    localparam int IDX_W = CNT_W - 1;

    typedef struct packed {
        logic [PART_W-1:0] part;
        logic [IDX_W-1:0]  idx;
        logic              odd;
        logic              long_clip;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    logic idx_full;

    assign idx_full = &cnt_q.idx;
    assign last_o   = idx_full && (!cnt_q.long_clip || cnt_q.part[0]);
    assign addr_o   = {cnt_q.part, cnt_q.idx, cnt_q.odd};

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d.part      = base_part_i;
            cnt_d.idx       = '0;
            cnt_d.odd       = 1'b0;
            cnt_d.long_clip = long_i;
        end else if (hi_byte_i) begin
            cnt_d.odd = 1'b1;
        end else if (advance_i) begin
            cnt_d.odd = 1'b0;
            if (idx_full) begin
                cnt_d.idx     = '0;
                cnt_d.part[0] = 1'b1;
            end else begin
                cnt_d.idx = cnt_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sfx_rate_timer.sv
module sfx_rate_timer #(
    parameter int PERIOD = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic slot_end_o
);

    localparam int TW = $clog2(PERIOD + 1);

    logic [TW-1:0] tick_d, tick_q;

    assign slot_end_o = (tick_q == TW'(PERIOD - 1));

    always_comb begin
        tick_d = tick_q;
        if (restart_i) begin
            tick_d = '0;
        end else if (run_i && !slot_end_o) begin
            tick_d = tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

endmodule

// File: rtl/audio_sfx_player.sv
module audio_sfx_player
    import audio_sfx_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PERIOD   = 250,
    parameter int WAIT_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    play_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [PART_W+CNT_W-1:0] rom_addr_o,
    input  logic [BYTE_W-1:0]       rom_data_i,
    output logic [SMP_W-1:0]        sample_o,
    output logic                    load_o,
    output logic                    playing_o
);

    localparam int WAIT_W = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        sfx_state_e        st;
        logic [WAIT_W-1:0] wcnt;
        logic [BYTE_W-1:0] lo;
        logic [SMP_W-1:0]  smp;
        logic              load;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [PART_W-1:0] base_part;
    logic              is_long;
    logic              start, hi_byte, advance, restart, last, slot_end;
    logic              wait_done;

    sfx_region_map u_map (
        .sel_i       (sel_i),
        .base_part_o (base_part),
        .long_o      (is_long)
    );

    sfx_addr_counter #(.CNT_W(CNT_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .base_part_i (base_part),
        .long_i      (is_long),
        .hi_byte_i   (hi_byte),
        .advance_i   (advance),
        .addr_o      (rom_addr_o),
        .last_o      (last)
    );

    sfx_rate_timer #(.PERIOD(PERIOD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (seq_q.st != ST_IDLE),
        .restart_i  (restart),
        .slot_end_o (slot_end)
    );

    assign wait_done = (seq_q.wcnt == WAIT_W'(WAIT_CYC - 1));

    always_comb begin
        seq_d      = seq_q;
        seq_d.load = 1'b0;
        start      = 1'b0;
        hi_byte    = 1'b0;
        advance    = 1'b0;
        restart    = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (play_i) begin
                    start      = 1'b1;
                    restart    = 1'b1;
                    seq_d.wcnt = '0;
                    seq_d.st   = ST_LO_WAIT;
                end
            end
            ST_LO_WAIT: begin
                if (wait_done) begin
                    seq_d.lo   = rom_data_i;
                    hi_byte    = 1'b1;
                    seq_d.wcnt = '0;
                    seq_d.st   = ST_HI_WAIT;
                end else begin
                    seq_d.wcnt = seq_q.wcnt + 1'b1;
                end
            end
            ST_HI_WAIT: begin
                if (wait_done) begin
                    seq_d.smp  = {rom_data_i, seq_q.lo};
                    seq_d.load = 1'b1;
                    seq_d.wcnt = '0;
                    seq_d.st   = last ? ST_LAST : ST_GAP;
                end else begin
                    seq_d.wcnt = seq_q.wcnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (slot_end) begin
                    advance    = 1'b1;
                    restart    = 1'b1;
                    seq_d.wcnt = '0;
                    seq_d.st   = ST_LO_WAIT;
                end
            end
            ST_LAST: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sample_o  = seq_q.smp;
    assign load_o    = seq_q.load;
    assign playing_o = (seq_q.st != ST_IDLE);

endmodule

// File: rtl/sfx_player_chk.sv
module sfx_player_chk #(
    parameter int CNT_W  = 16,
    parameter int PERIOD = 250
) (
    input logic                clk,
    input logic                rst_n,
    input logic                play_i,
    input logic [CNT_W+2:0]    rom_addr_o,
    input logic                load_o,
    input logic                playing_o
);

    localparam int AW = CNT_W + 3;
    localparam int GW = $clog2(PERIOD + 1);

    logic [GW-1:0] gap_q;
    logic          have_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            have_q <= 1'b0;
        end else begin
            if (load_o) begin
                gap_q  <= '0;
                have_q <= 1'b1;
            end else begin
                if (gap_q != GW'(PERIOD)) gap_q <= gap_q + 1'b1;
                if (!playing_o) have_q <= 1'b0;
            end
        end
    end

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) load_o |=> !load_o); // R5
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) load_o |-> playing_o); // R5
    AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n) (load_o && have_q) |-> (gap_q == GW'(PERIOD - 1))); // R5
    AST_START: assert property (@(posedge clk) disable iff (!rst_n) (!playing_o && play_i) |=> playing_o); // R2
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(playing_o) |-> (rom_addr_o[CNT_W-1:0] == '0)); // R2
    AST_LONG_EVEN: assert property (@(posedge clk) disable iff (!rst_n) ($rose(playing_o) && rom_addr_o[AW-1]) |-> !rom_addr_o[CNT_W]); // R3
    AST_HOLD_SOUND: assert property (@(posedge clk) disable iff (!rst_n) (playing_o && $past(playing_o)) |-> $stable(rom_addr_o[AW-1 -: 2])); // R7

endmodule

bind audio_sfx_player sfx_player_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .play_i     (play_i),
    .rom_addr_o (rom_addr_o),
    .load_o     (load_o),
    .playing_o  (playing_o)
);

// File: tb/audio_sfx_player_tb.sv
`timescale 1ns/1ps
module audio_sfx_player_tb;

    localparam int CNT_W = 4;
    localparam int P     = 10;
    localparam int W     = 2;
    localparam int AW    = CNT_W + 3;
    localparam int N     = 1 << (CNT_W - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          play = 1'b0;
    logic [2:0]    sel = '0;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic [15:0]   sample;
    logic          load;
    logic          playing;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] rom_byte(input int a);
        int t;
        t = a * 29 + 7 + (a >> 3);
        return t[7:0];
    endfunction

    assign rom_data = rom_byte(int'(rom_addr));

    audio_sfx_player #(.CNT_W(CNT_W), .PERIOD(P), .WAIT_CYC(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_i     (play),
        .sel_i      (sel),
        .rom_addr_o (rom_addr),
        .rom_data_i (rom_data),
        .sample_o   (sample),
        .load_o     (load),
        .playing_o  (playing)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Plays one clip and checks every cycle against the computed schedule.
    task automatic run_sound(input logic [2:0] s, input bit intrude);
        int base, nsamp, last_c, loads, k, part, idx, lo, hi;
        bit exp_load, exp_play;
        base  = s[2] ? int'({s[2:1], 1'b0}) : int'(s);
        nsamp = s[2] ? 2 * N : N;
        last_c = (nsamp - 1) * P + 2 * W;
        loads = 0;
        @(negedge clk);
        play = 1'b1;
        sel  = s;
        @(negedge clk);
        play = 1'b0;
        // R2 / R3: start partition with zero offset right after acceptance
        chk(rom_addr == AW'(base << CNT_W), "R3", int'(rom_addr), base << CNT_W);
        for (int c = 0; c <= last_c + 2; c++) begin
            if (intrude && c == P + 1) begin
                play = 1'b1;
                sel  = s ^ 3'b110;
            end else begin
                play = 1'b0;
            end
            exp_load = (c >= 2 * W) && ((c - 2 * W) % P == 0) && ((c - 2 * W) / P < nsamp);
            // R5: strobe exactly on schedule, one cycle wide
            chk(load == exp_load, "R5", int'(load), int'(exp_load));
            if (load) loads++;
            if (load && exp_load) begin
                k    = (c - 2 * W) / P;
                part = base + ((k >= N) ? 1 : 0);
                idx  = k % N;
                lo   = rom_byte((part << CNT_W) + 2 * idx);
                hi   = rom_byte((part << CNT_W) + 2 * idx + 1);
                // R4: little-endian assembly; R3 partition step on long clips
                chk(sample == 16'((hi << 8) | lo), "R4", int'(sample), (hi << 8) | lo);
            end
            exp_play = (c <= last_c);
            // R8 falls after last strobe; R7 stays busy across intrusion
            chk(playing == exp_play, intrude ? "R7" : "R8", int'(playing), int'(exp_play));
            @(negedge clk);
        end
        play = 1'b0;
        // R6: total sample count for the clip
        chk(loads == nsamp, "R6", loads, nsamp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(playing == 1'b0, "R1", int'(playing), 0);
        chk(load == 1'b0, "R1", int'(load), 0);
        chk(rom_addr == '0, "R1", int'(rom_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(playing == 1'b0, "R1", int'(playing), 0);
        for (int s = 0; s < 8; s++) begin
            run_sound(3'(s), 1'b0);
        end
        // R7: requests during playback are dropped
        run_sound(3'd1, 1'b1);
        run_sound(3'd6, 1'b1);
        // R8: immediate restart right after a clip ends
        run_sound(3'd5, 1'b0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule